// File: doc/BRIEF.md
# Raster to 8x8 Block Reorder Unit

This unit accepts 8-bit pixel samples in raster order, left to right along each line and line after line. It emits them as complete 8x8 tiles, the unit a 2D-DCT stage consumes. Inside a tile, samples leave one tile row at a time. Across the image, tiles leave from left to right within each band of eight lines, and bands leave from top to bottom. No frame store is needed. Two eight-line bands serve as a ping-pong store: the input fills one band while the output drains the other.

Image width and height are runtime inputs. The width may be any value from 1 up to the `MAX_W` parameter, and the height may be any value of at least 1. When a dimension is not a multiple of eight, the unit fills the tiles at the right and bottom edges out to full 8x8 by repeating edge samples. Every output sample carries two markers: one flags the first sample of a tile, and one flags the last sample of the frame. Both sides use valid/ready handshakes and accept stalls at any cycle. A global synchronous enable freezes all state, which gives a standby mode.

Top module: `raster2block`

## Requirements
- R1: In the cycle after synchronous reset is released, with `en` high, `out_valid` is 0 and `in_ready` is 1.
- R2: Output sample k of a frame, with NB = ceil(width/8), comes from band b = k/(64*NB), tile t = (k mod 64*NB)/64, tile row r = (k mod 64)/8 and tile column c = k mod 8. It equals the input sample at column 8t+c, line 8b+r.
- R3: A tile column 8t+c at or beyond the image width takes the sample at column width-1 of the same line.
- R4: A line 8b+r at or beyond the image height takes the sample from line height-1 at the same, possibly clamped, column.
- R5: `out_sob` is 1 exactly on samples with r=0 and c=0. `out_eof` is 1 exactly on the last sample of the frame. The two are never 1 together.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` high and `out_data` unchanged.
- R7: `in_ready` drops only when both bands hold unread data. Take a width that is a multiple of 8, with `in_valid` and `out_ready` held high. Every input sample is then accepted without a stall, and outputs run without a gap from the first sample to the end of the frame. With `out_ready` held low, exactly 16 lines are accepted before the input stalls.
- R8: While `en` is 0, `in_ready` and `out_valid` read 0 and no register changes. Once `en` returns to 1, the stream continues intact.
- R9: Frames of different sizes run back to back. A new size takes effect once the previous frame's last sample has been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global enable; 0 freezes all state |
| cfg_width | input | $clog2(MAX_W+1) | Image width in samples, 1..MAX_W |
| cfg_height | input | H_BITS | Image height in lines, at least 1 |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample accepted this cycle when valid |
| in_data | input | DATA_W | Raster-order sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output sample |
| out_data | output | DATA_W | Block-order sample |
| out_sob | output | 1 | First sample of an 8x8 tile |
| out_eof | output | 1 | Last sample of the frame |

## Verification
The assertions assume that `cfg_width` and `cfg_height` stay within range and do not change while a frame is in flight. They also assume that a consumer treats a sample as transferred only on a cycle where `out_valid` and `out_ready` are both high. The bench changes the size only after the previous frame's final marked sample has been seen, keeps every width at or below `MAX_W`, and drives every input half a period away from the clock edge. The expected stream is rebuilt from the index formula and clamping rules of the requirements, against a pixel pattern that gives every column a distinct value.

// File: rtl/r2b_pkg.sv
package r2b_pkg;
   localparam int TILE     = 8;
   localparam int TILE_LOG = 3;
   localparam int NBANDS   = 2;
   typedef logic [TILE_LOG-1:0] tile_idx_t;
   typedef logic [TILE_LOG:0]   line_cnt_t;
endpackage

// File: rtl/r2b_band_store.sv
module r2b_band_store
   import r2b_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int MAX_W  = 64,
   localparam int CW    = $clog2(MAX_W),
   localparam int DEPTH = TILE * MAX_W,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              wr_band,
   input  tile_idx_t         wr_row,
   input  logic [CW-1:0]     wr_col,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_band,
   input  tile_idx_t         rd_row,
   input  logic [CW-1:0]     rd_col,
   output logic [DATA_W-1:0] rd_data
);
   logic [AW-1:0]     wr_addr, rd_addr;
   logic [DATA_W-1:0] bank_q [NBANDS];

   assign wr_addr = AW'(wr_row) * AW'(MAX_W) + AW'(wr_col);
   assign rd_addr = AW'(rd_row) * AW'(MAX_W) + AW'(rd_col);

   for (genvar b = 0; b < NBANDS; b++) begin : g_bank
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_band == 1'(b)))
            mem[wr_addr] <= wr_data;
      end
      assign bank_q[b] = mem[rd_addr];
   end

   assign rd_data = bank_q[rd_band];
endmodule

// File: rtl/r2b_writer.sv
module r2b_writer
   import r2b_pkg::*;
#(
   parameter int MAX_W  = 64,
   parameter int H_BITS = 12,
   localparam int CW     = $clog2(MAX_W),
   localparam int W_BITS = $clog2(MAX_W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [W_BITS-1:0] cfg_width,
   input  logic [H_BITS-1:0] cfg_height,
   input  logic              in_valid,
   input  logic [NBANDS-1:0] band_full,
   output logic              in_ready,
   output logic              wr_en,
   output logic              wr_band,
   output tile_idx_t         wr_row,
   output logic [CW-1:0]     wr_col,
   output logic              band_done,
   output line_cnt_t         done_lines,
   output logic              done_last
);
   logic [CW-1:0]     col_q;
   logic [H_BITS-1:0] line_q;
   logic              sel_q;
   logic              row_end, frame_end, band_end;

   assign in_ready   = en && !band_full[sel_q];
   assign wr_en      = in_valid && in_ready;
   assign wr_band    = sel_q;
   assign wr_row     = line_q[TILE_LOG-1:0];
   assign wr_col     = col_q;
   assign row_end    = (W_BITS'(col_q) == cfg_width - W_BITS'(1));
   assign frame_end  = (line_q == cfg_height - H_BITS'(1));
   assign band_end   = row_end && ((&wr_row) || frame_end);
   assign band_done  = wr_en && band_end;
   assign done_lines = {1'b0, wr_row} + line_cnt_t'(1);
   assign done_last  = frame_end;

   always_ff @(posedge clk) begin
      if (rst) begin
         col_q  <= '0;
         line_q <= '0;
         sel_q  <= 1'b0;
      end else if (wr_en) begin
         if (row_end) begin
            col_q  <= '0;
            line_q <= frame_end ? '0 : line_q + H_BITS'(1);
            if (band_end) sel_q <= ~sel_q;
         end else begin
            col_q <= col_q + CW'(1);
         end
      end
   end
endmodule

// File: rtl/r2b_reader.sv
module r2b_reader
   import r2b_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int MAX_W  = 64,
   localparam int CW     = $clog2(MAX_W),
   localparam int W_BITS = $clog2(MAX_W + 1),
   localparam int SW     = CW + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [W_BITS-1:0] cfg_width,
   input  logic              cur_full,
   input  line_cnt_t         cur_lines,
   input  logic              cur_last,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              out_ready,
   output logic              rd_band,
   output tile_idx_t         rd_row,
   output logic [CW-1:0]     rd_col,
   output logic              band_release,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sob,
   output logic              out_eof
);
   tile_idx_t     r_q, c_q;
   logic [CW-1:0] base_q;
   logic          sel_q, vld_q, step, tile_end, last_tile;
   logic [SW-1:0] col_sum, col_max;
   line_cnt_t     line_max;

   assign col_sum   = SW'(base_q) + SW'(c_q);
   assign col_max   = SW'(cfg_width) - SW'(1);
   assign line_max  = cur_lines - line_cnt_t'(1);
   assign rd_col    = (col_sum > col_max) ? CW'(col_max) : CW'(col_sum);
   assign rd_row    = ({1'b0, r_q} > line_max) ? line_max[TILE_LOG-1:0] : r_q;
   assign rd_band   = sel_q;
   assign last_tile = (SW'(base_q) + SW'(TILE)) >= SW'(cfg_width);
   assign tile_end  = (&r_q) && (&c_q);
   assign step      = en && cur_full && (!vld_q || out_ready);
   assign band_release = step && tile_end && last_tile;
   assign out_valid = vld_q && en;

   always_ff @(posedge clk) begin
      if (rst) begin
         r_q <= '0; c_q <= '0; base_q <= '0; sel_q <= 1'b0;
         vld_q <= 1'b0; out_data <= '0; out_sob <= 1'b0; out_eof <= 1'b0;
      end else if (step) begin
         vld_q    <= 1'b1;
         out_data <= rd_data;
         out_sob  <= (r_q == '0) && (c_q == '0);
         out_eof  <= cur_last && last_tile && tile_end;
         c_q      <= c_q + tile_idx_t'(1);
         if (&c_q) begin
            r_q <= r_q + tile_idx_t'(1);
            if (&r_q) begin
               if (last_tile) begin
                  base_q <= '0;
                  sel_q  <= ~sel_q;
               end else begin
                  base_q <= base_q + CW'(TILE);
               end
            end
         end
      end else if (en && out_ready) begin
         vld_q <= 1'b0;
      end
   end
endmodule

// File: rtl/raster2block.sv
module raster2block
   import r2b_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int MAX_W  = 64,
   parameter int H_BITS = 12,
   localparam int CW     = $clog2(MAX_W),
   localparam int W_BITS = $clog2(MAX_W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [W_BITS-1:0] cfg_width,
   input  logic [H_BITS-1:0] cfg_height,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sob,
   output logic              out_eof
);
   initial begin
      assert (MAX_W >= TILE && (MAX_W % TILE) == 0)
         else $fatal(1, "MAX_W must be a positive multiple of the tile size");
      assert (DATA_W > 0) else $fatal(1, "DATA_W must be positive");
      assert (H_BITS > TILE_LOG) else $fatal(1, "H_BITS too small");
   end

   logic [NBANDS-1:0] full_q, last_q;
   line_cnt_t         lines_q [NBANDS];
   logic              wr_en, wr_band, band_done, done_last;
   tile_idx_t         wr_row, rd_row;
   logic [CW-1:0]     wr_col, rd_col;
   line_cnt_t         done_lines;
   logic              rd_band, band_release;
   logic [DATA_W-1:0] rd_data;

   r2b_writer #(.MAX_W(MAX_W), .H_BITS(H_BITS)) u_wr (
      .clk, .rst, .en, .cfg_width, .cfg_height, .in_valid,
      .band_full(full_q), .in_ready, .wr_en, .wr_band, .wr_row, .wr_col,
      .band_done, .done_lines, .done_last
   );

   r2b_band_store #(.DATA_W(DATA_W), .MAX_W(MAX_W)) u_store (
      .clk, .wr_en, .wr_band, .wr_row, .wr_col, .wr_data(in_data),
      .rd_band, .rd_row, .rd_col, .rd_data
   );

   r2b_reader #(.DATA_W(DATA_W), .MAX_W(MAX_W)) u_rd (
      .clk, .rst, .en, .cfg_width,
      .cur_full(full_q[rd_band]), .cur_lines(lines_q[rd_band]),
      .cur_last(last_q[rd_band]), .rd_data, .out_ready,
      .rd_band, .rd_row, .rd_col, .band_release,
      .out_valid, .out_data, .out_sob, .out_eof
   );

   for (genvar b = 0; b < NBANDS; b++) begin : g_band_state
      always_ff @(posedge clk) begin
         if (rst) begin
            full_q[b]  <= 1'b0;
            last_q[b]  <= 1'b0;
            lines_q[b] <= '0;
         end else if (en) begin
            if (band_release && (rd_band == 1'(b))) full_q[b] <= 1'b0;
            if (band_done && (wr_band == 1'(b))) begin
               full_q[b]  <= 1'b1;
               last_q[b]  <= done_last;
               lines_q[b] <= done_lines;
            end
         end
      end
   end
endmodule

// File: rtl/r2b_checker.sv
module r2b_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              en,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_sob,
   input logic              out_eof,
   input logic [1:0]        full_q
);
   AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R1

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (!en || out_valid) && $stable(out_data)); // R6

   AST_MARK_EXCL: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !(out_sob && out_eof)); // R5

   AST_BOTH_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
      (&full_q) |-> !in_ready); // R7

   AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
      !en |-> (!in_ready && !out_valid)); // R8

   AST_STANDBY_FREEZE: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(out_data) && $stable(full_q) && $stable(out_sob))); // R8
endmodule

bind raster2block r2b_checker #(.DATA_W(DATA_W)) u_chk (
   .clk, .rst, .en, .in_ready, .out_valid, .out_ready,
   .out_data, .out_sob, .out_eof, .full_q
);

// File: tb/raster2block_bench.sv
module raster2block_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_W  = 64;
   localparam int H_BITS = 12;
   localparam int W_BITS = $clog2(MAX_W + 1);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 1'b1;
   logic [W_BITS-1:0] cfg_width = W_BITS'(8);
   logic [H_BITS-1:0] cfg_height = H_BITS'(8);
   logic in_valid = 1'b0;
   logic in_ready;
   logic [7:0] in_data = '0;
   logic out_valid;
   logic out_ready = 1'b1;
   logic [7:0] out_data;
   logic out_sob, out_eof;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;
   int acc_count = 0;

   raster2block #(.DATA_W(8), .MAX_W(MAX_W), .H_BITS(H_BITS)) u_raster2block (
      .clk, .rst, .en, .cfg_width, .cfg_height, .in_valid, .in_ready, .in_data,
      .out_valid, .out_ready, .out_data, .out_sob, .out_eof
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   function automatic logic [7:0] pix(input int f, input int x, input int y);
      return 8'((x * 5 + y * 17 + f * 29) & 255);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // rmode: 0 ready always, 1 pseudo-random ready, 2 ready held low for 300 cycles
   task automatic run_frame(input int w, input int h, input int f, input int rmode,
                            input bit stdby, output int stalls, output int gaps);
      int nb, total;
      nb = (w + 7) / 8;
      total = ((h + 7) / 8) * nb * 64;
      stalls = 0;
      gaps = 0;
      acc_count = 0;
      cfg_width = W_BITS'(w);
      cfg_height = H_BITS'(h);
      fork
         begin : drive
            int idx = 0;
            while (idx < w * h) begin
               @(negedge clk);
               in_valid = 1'b1;
               in_data = pix(f, idx % w, idx / w);
               #1;
               if (in_ready) begin idx++; acc_count++; end
               else stalls++;
            end
            @(negedge clk);
            in_valid = 1'b0;
         end
         begin : watch
            int k = 0;
            int cyc = 0;
            bit started = 0;
            bit hold = 0;
            logic [7:0] held = '0;
            logic [15:0] lfsr = 16'hACE1;
            while (k < total) begin
               @(negedge clk);
               cyc++;
               lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
               case (rmode)
                  1: out_ready = lfsr[0] | lfsr[3];
                  2: out_ready = (cyc > 300);
                  default: out_ready = 1'b1;
               endcase
               en = !(stdby && cyc >= 30 && cyc < 36);
               #1;
               if (rmode == 2 && cyc == 300)
                  chk(acc_count == 16 * w, "R7 both bands full", acc_count, 16 * w);
               if (!en) begin
                  chk(!in_ready && !out_valid, "R8 standby quiet",
                      int'({in_ready, out_valid}), 0);
                  hold = 0;
               end else begin
                  if (hold)
                     chk(out_valid && out_data == held, "R6 stall hold", int'(out_data), int'(held));
                  hold = out_valid && !out_ready;
                  held = out_data;
                  if (started && !out_valid) gaps++;
                  if (out_valid && out_ready) begin
                     int b, t, r, c, xr, yr, xc, yc;
                     string tag;
                     started = 1;
                     b = k / (64 * nb);
                     t = (k % (64 * nb)) / 64;
                     r = (k % 64) / 8;
                     c = k % 8;
                     xr = 8 * t + c;
                     yr = 8 * b + r;
                     xc = (xr >= w) ? w - 1 : xr;
                     yc = (yr >= h) ? h - 1 : yr;
                     tag = (xr >= w) ? "R3 right pad" : (yr >= h) ? "R4 bottom pad" : "R2 order";
                     chk(out_data == pix(f, xc, yc), tag, int'(out_data), int'(pix(f, xc, yc)));
                     chk(out_sob == (r == 0 && c == 0), "R5 sob", int'(out_sob), int'(r == 0 && c == 0));
                     chk(out_eof == (k == total - 1), "R5 eof", int'(out_eof), int'(k == total - 1));
                     k++;
                  end
               end
            end
            en = 1'b1;
            out_ready = 1'b1;
         end
      join
   endtask

   task automatic test_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
   endtask

   task automatic test_aligned();
      int s, g;
      run_frame(16, 24, 1, 0, 0, s, g);
      chk(s == 0, "R7 input stall cycles", s, 0);
      chk(g == 0, "R7 output gap cycles", g, 0);
   endtask

   task automatic test_padded();
      int s, g;
      run_frame(13, 11, 2, 0, 0, s, g);
   endtask

   task automatic test_backpressure_and_resize();
      int s, g;
      run_frame(20, 9, 3, 1, 0, s, g);
      run_frame(8, 8, 4, 0, 0, s, g);   // R9 new size right after eof
      run_frame(27, 17, 5, 1, 0, s, g); // R9
   endtask

   task automatic test_standby();
      int s, g;
      run_frame(16, 16, 6, 0, 1, s, g);
   endtask

   task automatic test_extremes();
      int s, g;
      run_frame(MAX_W, 8, 7, 0, 0, s, g);
      chk(s == 0, "R7 max width stall cycles", s, 0);
      run_frame(1, 1, 8, 0, 0, s, g);
   endtask

   task automatic test_both_full();
      int s, g;
      run_frame(8, 24, 9, 2, 0, s, g);
   endtask

   initial begin
      test_reset();
      test_aligned();
      test_padded();
      test_backpressure_and_resize();
      test_standby();
      test_extremes();
      test_both_full();
      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule